// File: doc/BRIEF.md
# Rename History Buffer with Rollback and Retirement

This block keeps an ordered log of register renames for one thread of an out-of-order core. Each time the rename stage gives a destination register a fresh physical register, it appends a record here. A record holds the instruction's sequence number, the architectural register, the physical register just granted, and the physical register that the architectural register pointed to before. The log is a circular FIFO. The youngest record sits at the tail and the oldest at the head.

Two walks drain the log, and each handles one record per cycle. A squash walks from the youngest end. For each record it restores the old mapping through a map-table write port and hands the new physical register back through a free-list port. A new register numbered past the real integer and floating-point pool also gets a scoreboard ready write. A commit walks from the oldest end and gives back the superseded physical register of every record it retires. A flush rolls back every record whatever its sequence number. Two counters report how many mappings have been retired and how many have been undone.

Top module: `rename_hist_buf`

## Requirements
- R1: After reset the log is empty. `busy` is 0 and `alloc_ready` is 1. `map_wr_en`, `free_wr_en` and `ready_set_en` are 0, and both counters read 0.
- R2: A record is appended at the youngest end on a clock edge where `alloc_valid` and `alloc_ready` are both 1. `alloc_ready` is 0 while the log holds DEPTH records.
- R3: A `squash_valid` pulse raises `busy` from the next cycle. In each busy cycle the youngest record is undone if its sequence number is greater than `squash_seq` (unsigned compare, no wrap). Undoing a record drives `map_wr_en` with `map_wr_arch` = its architectural register and `map_wr_phys` = its previous physical register. In the same cycle it drives `free_wr_en` with `free_wr_phys` = its new physical register. The first cycle with nothing to undo writes nothing, and `busy` is 0 in the cycle after it.
- R4: An undone record whose new physical register is at least NUM_REAL also drives `ready_set_en`, with `ready_set_phys` = that register. An undone record below NUM_REAL leaves `ready_set_en` at 0.
- R5: A `flush_valid` pulse starts the same walk as a squash, but it undoes every record regardless of sequence number, youngest first, until the log is empty.
- R6: A `commit_valid` pulse starts a retirement walk in the next cycle. Each cycle it retires the oldest record if that record's sequence number is at most `commit_seq`. Retiring drives `free_wr_en` with `free_wr_phys` = the record's previous physical register, and `map_wr_en` stays 0.
- R7: A commit has no effect (no free write and no count change) when the log is empty or when its oldest record's sequence number is greater than `commit_seq`.
- R8: A commit is ignored when it arrives in the same cycle as `squash_valid` or `flush_valid`, or while `busy` is 1. In those cycles a free write only ever occurs together with a map write.
- R9: A squash or flush has priority over allocation. `alloc_ready` is 0 in any cycle where `squash_valid` or `flush_valid` is 1, and in any cycle where `busy` is 1.
- R10: `commit_count` adds one for each retired record, and `undo_count` adds one for each undone record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to append a rename record |
| alloc_seq | input | SEQ_W | Sequence number of the renamed instruction |
| alloc_arch | input | ARCH_W | Architectural destination register |
| alloc_new_phys | input | PHYS_W | Newly granted physical register |
| alloc_prev_phys | input | PHYS_W | Physical register previously mapped |
| alloc_ready | output | 1 | Append accepted this cycle if requested |
| squash_valid | input | 1 | Start a rollback to squash_seq |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| flush_valid | input | 1 | Roll back every record |
| commit_valid | input | 1 | Retire records up to commit_seq |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| busy | output | 1 | Rollback walk in progress |
| map_wr_en | output | 1 | Map-table restore write |
| map_wr_arch | output | ARCH_W | Architectural register to restore |
| map_wr_phys | output | PHYS_W | Physical register written back to the map |
| free_wr_en | output | 1 | Free-list return write |
| free_wr_phys | output | PHYS_W | Physical register returned |
| ready_set_en | output | 1 | Scoreboard mark-ready write |
| ready_set_phys | output | PHYS_W | Register marked ready |
| commit_count | output | CNT_W | Total retired mappings |
| undo_count | output | CNT_W | Total undone mappings |

## Verification
The bench builds the block with DEPTH = 4, PHYS_W = 5 and NUM_REAL = 24, and keeps the other parameters at their defaults. A depth of four lets a handful of appends fill the log, so the full condition and a flush of a completely full log can both be observed. A pool threshold of 24 inside a 32-entry register space allows one record to carry a new register above the threshold and a neighbouring record to carry one below it. A single squash walk then shows the scoreboard write switching on and off. Small sequence numbers make it easy to place the squash and commit boundaries exactly between two records.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE     = 2'd0,
        WALK_ROLLBACK = 2'd1,
        WALK_RETIRE   = 2'd2
    } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
    parameter int DEPTH = 32,
    parameter int REC_W = 44,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [REC_W-1:0] wr_rec,
    input  logic [PTR_W-1:0] young_ptr,
    input  logic [PTR_W-1:0] old_ptr,
    output logic [REC_W-1:0] young_rec,
    output logic [REC_W-1:0] old_rec
);
    logic [REC_W-1:0] slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots_q[wr_ptr] <= wr_rec;
        end
    end

    assign young_rec = slots_q[young_ptr];
    assign old_rec   = slots_q[old_ptr];
endmodule

// File: rtl/rhb_event_ctr.sv
module rhb_event_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] total
);
    logic [W-1:0] total_d, total_q;

    always_comb begin
        total_d = total_q + W'(bump);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign total = total_q;
endmodule

// File: rtl/rhb_ctrl.sv
module rhb_ctrl #(
    parameter int DEPTH    = 32,
    parameter int SEQ_W    = 16,
    parameter int ARCH_W   = 5,
    parameter int PHYS_W   = 7,
    parameter int NUM_REAL = 96,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int OCC_W = PTR_W + 1,
    localparam int REC_W = SEQ_W + ARCH_W + 2 * PHYS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_valid,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic [REC_W-1:0]  young_rec,
    input  logic [REC_W-1:0]  old_rec,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  young_ptr,
    output logic [PTR_W-1:0]  old_ptr,
    output logic [OCC_W-1:0]  occ,
    output logic              busy,
    output logic              undo,
    output logic              retire,
    output logic              map_wr_en,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_wr_en,
    output logic [PHYS_W-1:0] free_wr_phys,
    output logic              ready_set_en,
    output logic [PHYS_W-1:0] ready_set_phys
);
    import rhb_pkg::*;

    typedef struct packed {
        walk_e             mode;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [OCC_W-1:0]  occ;
        logic [SEQ_W-1:0]  limit;
        logic              wipe;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [SEQ_W-1:0]  y_seq, o_seq;
    logic [ARCH_W-1:0] y_arch;
    logic [PHYS_W-1:0] y_new, y_prev, o_prev;
    logic              cut_req, log_empty, log_full, accept;

    // record layout: {seq, arch, new phys, prev phys}
    assign y_seq  = young_rec[REC_W-1 -: SEQ_W];
    assign y_arch = young_rec[2*PHYS_W +: ARCH_W];
    assign y_new  = young_rec[PHYS_W +: PHYS_W];
    assign y_prev = young_rec[0 +: PHYS_W];
    assign o_seq  = old_rec[REC_W-1 -: SEQ_W];
    assign o_prev = old_rec[0 +: PHYS_W];

    always_comb begin
        st_d      = st_q;
        cut_req   = squash_valid || flush_valid;
        log_empty = (st_q.occ == '0);
        log_full  = (st_q.occ == OCC_W'(DEPTH));

        alloc_ready = !log_full && (st_q.mode != WALK_ROLLBACK) && !cut_req;
        accept      = alloc_valid && alloc_ready;

        undo   = (st_q.mode == WALK_ROLLBACK) && !log_empty &&
                 (st_q.wipe || (y_seq > st_q.limit));
        retire = (st_q.mode == WALK_RETIRE) && !cut_req && !log_empty &&
                 (o_seq <= st_q.limit);

        case (st_q.mode)
            WALK_IDLE: begin
                if (commit_valid && !cut_req) begin
                    st_d.mode  = WALK_RETIRE;
                    st_d.limit = commit_seq;
                end
            end
            WALK_RETIRE: begin
                if (commit_valid) begin
                    st_d.limit = commit_seq;
                end else if (!retire) begin
                    st_d.mode = WALK_IDLE;
                end
            end
            WALK_ROLLBACK: begin
                if (!undo) begin
                    st_d.mode = WALK_IDLE;
                    st_d.wipe = 1'b0;
                end
            end
            default: st_d.mode = WALK_IDLE;
        endcase

        if (undo)   st_d.tail = st_q.tail - PTR_W'(1);
        if (accept) st_d.tail = st_q.tail + PTR_W'(1);
        if (retire) st_d.head = st_q.head + PTR_W'(1);
        st_d.occ = st_q.occ + OCC_W'(accept) - OCC_W'(undo) - OCC_W'(retire);

        if (cut_req) begin
            st_d.mode  = WALK_ROLLBACK;
            st_d.limit = squash_seq;
            st_d.wipe  = flush_valid;
        end

        wr_en     = accept;
        wr_ptr    = st_q.tail;
        young_ptr = st_q.tail - PTR_W'(1);
        old_ptr   = st_q.head;
        occ       = st_q.occ;
        busy      = (st_q.mode == WALK_ROLLBACK);

        map_wr_en      = undo;
        map_wr_arch    = y_arch;
        map_wr_phys    = y_prev;
        free_wr_en     = undo || retire;
        free_wr_phys   = undo ? y_new : o_prev;
        ready_set_en   = undo && (int'(y_new) >= NUM_REAL);
        ready_set_phys = y_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= WALK_IDLE;
            st_q.head  <= '0;
            st_q.tail  <= '0;
            st_q.occ   <= '0;
            st_q.limit <= '0;
            st_q.wipe  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
    parameter int DEPTH    = 32,
    parameter int SEQ_W    = 16,
    parameter int ARCH_W   = 5,
    parameter int PHYS_W   = 7,
    parameter int NUM_REAL = 96,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ARCH_W-1:0] alloc_arch,
    input  logic [PHYS_W-1:0] alloc_new_phys,
    input  logic [PHYS_W-1:0] alloc_prev_phys,
    output logic              alloc_ready,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush_valid,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              busy,
    output logic              map_wr_en,
    output logic [ARCH_W-1:0] map_wr_arch,
    output logic [PHYS_W-1:0] map_wr_phys,
    output logic              free_wr_en,
    output logic [PHYS_W-1:0] free_wr_phys,
    output logic              ready_set_en,
    output logic [PHYS_W-1:0] ready_set_phys,
    output logic [CNT_W-1:0]  commit_count,
    output logic [CNT_W-1:0]  undo_count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int OCC_W = PTR_W + 1;
    localparam int REC_W = SEQ_W + ARCH_W + 2 * PHYS_W;

    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr, young_ptr, old_ptr;
    logic [REC_W-1:0]  young_rec, old_rec, wr_rec;
    logic [OCC_W-1:0]  occ;
    logic              undo_p, retire_p;

    assign wr_rec = {alloc_seq, alloc_arch, alloc_new_phys, alloc_prev_phys};

    rhb_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk       (clk),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_rec    (wr_rec),
        .young_ptr (young_ptr),
        .old_ptr   (old_ptr),
        .young_rec (young_rec),
        .old_rec   (old_rec)
    );

    rhb_ctrl #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W),
        .PHYS_W(PHYS_W), .NUM_REAL(NUM_REAL)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid    (alloc_valid),
        .alloc_ready    (alloc_ready),
        .squash_valid   (squash_valid),
        .squash_seq     (squash_seq),
        .flush_valid    (flush_valid),
        .commit_valid   (commit_valid),
        .commit_seq     (commit_seq),
        .young_rec      (young_rec),
        .old_rec        (old_rec),
        .wr_en          (wr_en),
        .wr_ptr         (wr_ptr),
        .young_ptr      (young_ptr),
        .old_ptr        (old_ptr),
        .occ            (occ),
        .busy           (busy),
        .undo           (undo_p),
        .retire         (retire_p),
        .map_wr_en      (map_wr_en),
        .map_wr_arch    (map_wr_arch),
        .map_wr_phys    (map_wr_phys),
        .free_wr_en     (free_wr_en),
        .free_wr_phys   (free_wr_phys),
        .ready_set_en   (ready_set_en),
        .ready_set_phys (ready_set_phys)
    );

    rhb_event_ctr #(.W(CNT_W)) u_commit_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (retire_p),
        .total (commit_count)
    );

    rhb_event_ctr #(.W(CNT_W)) u_undo_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (undo_p),
        .total (undo_count)
    );
endmodule

// File: rtl/rhb_checker.sv
module rhb_checker #(
    parameter int DEPTH    = 32,
    parameter int PHYS_W   = 7,
    parameter int NUM_REAL = 96,
    parameter int OCC_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alloc_valid,
    input logic              alloc_ready,
    input logic              squash_valid,
    input logic              flush_valid,
    input logic              busy,
    input logic              map_wr_en,
    input logic              free_wr_en,
    input logic              ready_set_en,
    input logic [PHYS_W-1:0] ready_set_phys,
    input logic [OCC_W-1:0]  occ
);
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready) |-> (int'(occ) < DEPTH));

    assert_restore_in_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_en |-> (busy && free_wr_en));

    assert_busy_from_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(squash_valid || flush_valid));

    assert_misc_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready_set_en |-> (map_wr_en && int'(ready_set_phys) >= NUM_REAL));

    assert_no_retire_in_squash_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid || flush_valid || busy) |-> !(free_wr_en && !map_wr_en));

    assert_cut_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid || flush_valid || busy) |-> !alloc_ready);
endmodule

bind rename_hist_buf rhb_checker #(
    .DEPTH(DEPTH), .PHYS_W(PHYS_W), .NUM_REAL(NUM_REAL), .OCC_W(OCC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_valid    (alloc_valid),
    .alloc_ready    (alloc_ready),
    .squash_valid   (squash_valid),
    .flush_valid    (flush_valid),
    .busy           (busy),
    .map_wr_en      (map_wr_en),
    .free_wr_en     (free_wr_en),
    .ready_set_en   (ready_set_en),
    .ready_set_phys (ready_set_phys),
    .occ            (occ)
);

// File: tb/sim_rename_hist_buf.sv
`timescale 1ns/1ps
module sim_rename_hist_buf;
    localparam int DEPTH = 4, SEQ_W = 16, ARCH_W = 5, PHYS_W = 5, NUM_REAL = 24, CNT_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, squash_valid = 0, flush_valid = 0, commit_valid = 0;
    logic [SEQ_W-1:0]  alloc_seq = '0, squash_seq = '0, commit_seq = '0;
    logic [ARCH_W-1:0] alloc_arch = '0;
    logic [PHYS_W-1:0] alloc_new_phys = '0, alloc_prev_phys = '0;
    logic alloc_ready, busy, map_wr_en, free_wr_en, ready_set_en;
    logic [ARCH_W-1:0] map_wr_arch;
    logic [PHYS_W-1:0] map_wr_phys, free_wr_phys, ready_set_phys;
    logic [CNT_W-1:0]  commit_count, undo_count;

    int vectors = 0, fails = 0;

    always #4 clk = ~clk;

    rename_hist_buf #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W),
        .NUM_REAL(NUM_REAL), .CNT_W(CNT_W)
    ) u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push(input int s, input int a, input int n, input int p);
        cyc();
        alloc_valid = 1; alloc_seq = SEQ_W'(s); alloc_arch = ARCH_W'(a);
        alloc_new_phys = PHYS_W'(n); alloc_prev_phys = PHYS_W'(p);
        #1 chk(alloc_ready == 1'b1, "R2 append accepted", int'(alloc_ready), 1);
        cyc();
        alloc_valid = 0;
    endtask

    // one undo cycle: map (arch, prev), free new
    task automatic see_undo(input int a, input int p, input int n, input bit sb, input string req);
        #1;
        chk(map_wr_en == 1'b1, req, int'(map_wr_en), 1);
        chk(int'(map_wr_arch) == a, req, int'(map_wr_arch), a);
        chk(int'(map_wr_phys) == p, req, int'(map_wr_phys), p);
        chk(free_wr_en == 1'b1 && int'(free_wr_phys) == n, req, int'(free_wr_phys), n);
        chk(ready_set_en == sb, "R4 scoreboard write", int'(ready_set_en), int'(sb));
        if (sb) chk(int'(ready_set_phys) == n, "R4 ready phys", int'(ready_set_phys), n);
    endtask

    task automatic see_quiet(input string req);
        #1;
        chk(free_wr_en == 1'b0 && map_wr_en == 1'b0, req, int'(free_wr_en), 0);
    endtask

    task automatic t_reset();
        #1;
        chk(alloc_ready == 1'b1, "R1 alloc_ready", int'(alloc_ready), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(!map_wr_en && !free_wr_en && !ready_set_en, "R1 writes idle", int'(free_wr_en), 0);
        chk(commit_count == 0 && undo_count == 0, "R1 counters", int'(undo_count), 0);
    endtask

    task automatic t_commit();
        push(10, 1, 20, 1);
        push(11, 2, 21, 2);
        push(12, 3, 22, 3);
        commit_valid = 1; commit_seq = 11;
        see_quiet("R6 no retire before walk");
        cyc(); commit_valid = 0;
        #1 chk(free_wr_en && !map_wr_en && free_wr_phys == 1, "R6 retire oldest", int'(free_wr_phys), 1);
        cyc();
        #1 chk(free_wr_en && !map_wr_en && free_wr_phys == 2, "R6 retire second", int'(free_wr_phys), 2);
        cyc(); see_quiet("R6 walk stops at boundary");
        cyc(); #1 chk(commit_count == 2, "R10 commit_count", int'(commit_count), 2);
    endtask

    task automatic t_commit_old();
        cyc(); commit_valid = 1; commit_seq = 5;
        cyc(); commit_valid = 0; see_quiet("R7 older commit ignored");
        cyc(); see_quiet("R7 older commit ignored later");
        #1 chk(commit_count == 2, "R7 count unchanged", int'(commit_count), 2);
    endtask

    task automatic t_squash();
        push(13, 4, 25, 4);
        push(14, 5, 23, 5);
        cyc(); squash_valid = 1; squash_seq = 12; alloc_valid = 1;
        #1 chk(alloc_ready == 1'b0, "R9 squash beats append", int'(alloc_ready), 0);
        cyc(); squash_valid = 0; alloc_valid = 0;
        #1 chk(busy == 1'b1, "R3 busy raised", int'(busy), 1);
        see_undo(5, 5, 23, 0, "R3 undo youngest");
        cyc(); see_undo(4, 4, 25, 1, "R3 undo second");
        cyc(); see_quiet("R3 stop at boundary");
        chk(busy == 1'b1, "R3 busy on final check", int'(busy), 1);
        cyc(); #1 chk(busy == 1'b0, "R3 busy drops", int'(busy), 0);
        chk(undo_count == 2, "R10 undo_count", int'(undo_count), 2);
    endtask

    task automatic t_full_flush();
        push(15, 6, 10, 6);
        push(16, 7, 11, 7);
        push(17, 8, 12, 8);
        #1 chk(alloc_ready == 1'b0, "R2 full refuses", int'(alloc_ready), 0);
        cyc(); flush_valid = 1; squash_seq = 100;
        cyc(); flush_valid = 0;
        see_undo(8, 8, 12, 0, "R5 flush undo 17");
        cyc(); see_undo(7, 7, 11, 0, "R5 flush undo 16");
        cyc(); see_undo(6, 6, 10, 0, "R5 flush undo 15");
        cyc(); see_undo(3, 3, 22, 0, "R5 flush undo 12");
        cyc(); see_quiet("R5 flush ends when empty");
        cyc(); #1 chk(busy == 1'b0 && alloc_ready == 1'b1, "R5 flush done", int'(alloc_ready), 1);
        chk(undo_count == 6, "R10 undo_count after flush", int'(undo_count), 6);
        commit_valid = 1; commit_seq = 200;
        cyc(); commit_valid = 0; see_quiet("R7 empty commit ignored");
        cyc(); see_quiet("R7 empty commit ignored later");
    endtask

    task automatic t_commit_vs_squash();
        push(30, 9, 13, 9);
        push(31, 10, 14, 10);
        cyc(); squash_valid = 1; squash_seq = 30; commit_valid = 1; commit_seq = 31;
        see_quiet("R8 no retire in squash cycle");
        cyc(); squash_valid = 0; commit_valid = 0;
        see_undo(10, 10, 14, 0, "R8 squash undo 31");
        cyc(); commit_valid = 1; commit_seq = 31;
        see_quiet("R8 commit ignored while busy");
        cyc(); commit_valid = 0;
        see_quiet("R8 ignored commit leaves no walk");
        cyc(); see_quiet("R8 still quiet");
        commit_valid = 1; commit_seq = 30;
        cyc(); commit_valid = 0;
        #1 chk(free_wr_en && !map_wr_en && free_wr_phys == 9, "R6 retire after squash", int'(free_wr_phys), 9);
        cyc(); see_quiet("R6 empty after retire");
        cyc(); #1 chk(commit_count == 3 && undo_count == 7, "R10 final counts", int'(commit_count), 3);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_commit();
        t_commit_old();
        t_squash();
        t_full_flush();
        t_commit_vs_squash();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule